// File: doc/BRIEF.md
# Configurable General Purpose Timer

A register-mapped timer peripheral built from two half-width counter lanes, A and B. A configuration register chooses how they are used. Value 0 joins both halves into one full-width down-counter, which runs periodically or as a one-shot. Value 1 turns the block into a full-width real-time counter that advances on an external seconds strobe and flags a match. Values 4 and above split it into two independent half-width down-counters. Values 2 and 3 leave every counter idle.

Software talks to the block through a single-cycle write strobe and a combinational read port. One level interrupt combines the raw event bits through a mask. In joined mode a timeout can also drive a one-cycle pulse on a trigger line, which another peripheral such as a sampling converter can use as a start signal. Each lane counts at a rate set by its own prescaler. Half width, prescaler width and bus width are parameters.

Top module: `gp_timer`

## Requirements
- R1: After reset the configuration (0x00), control (0x0C), raw status (0x1C) and mask (0x18) registers read zero, and `irq` and `trig` are low.
- R2: With configuration 0, writing control bit 0 from 0 to 1 loads the counter with {B load, A load}. The counter steps once every A-prescale+1 clocks, and the timeout (raw status bit 0) sets (load+1)*(prescale+1) clocks after the enabling write.
- R3: With bit 0 of the A mode register (0x04) clear, the counter reloads at each timeout and keeps producing timeouts at the same interval.
- R4: With A mode bit 0 set, the timeout clears control bit 0, and counting stops.
- R5: When control bit 5 is set, each timeout in configuration 0 produces a one-cycle `trig` pulse on the same edge that sets raw status bit 0. No pulse appears in any other configuration or while bit 5 is clear.
- R6: With configuration 1, the 0-to-1 edge of control bit 0 loads the real-time counter from the combined load value. Each cycle with `rtc_tick` high adds one. Raw status bit 3 sets when the new value equals {B match, A match}, and the counter value reads at 0x48.
- R7: With configuration 4 or above, lane A (control bit 0, A mode, A load 0x28, A prescale 0x38) sets raw bit 0, and lane B (control bit 8, B mode 0x08, B load 0x2C, B prescale 0x3C) independently sets raw bit 8. Below configuration 4, control bit 8 has no effect.
- R8: Below configuration 4, a write to 0x28 or 0x30 puts the low half into A and the upper half into B, and a read returns the combined value. From configuration 4 up, such a write leaves B unchanged and a read returns only the A half.
- R9: The mask register (0x18) keeps only the bits set in 0x77. `irq` is high exactly when raw status AND mask is non-zero, and 0x20 reads that AND.
- R10: Writing ones to 0x24 clears the matching raw status bits. An event arriving in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rtc_tick | input | 1 | Seconds strobe for the real-time counter |
| irq | output | 1 | Masked interrupt level |
| trig | output | 1 | One-cycle timeout pulse for another peripheral |

## Verification
On every cycle the assertions check four things. A trigger pulse always comes with the A timeout bit and always follows a cycle in joined mode with trigger enabled. A one-shot timeout drops its enable. The lane B timeout bit and the match bit rise only in their own configurations. Exact timeout instants, the way the load halves combine, the readback width in each configuration, mask truncation and write-one-to-clear can only be shown by the scenarios. There, a scoreboard pairs every trigger pulse with the cycle the bench predicted for it, and timed register polls bracket each expected event.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   localparam int ADDR_W = 8;
   localparam int CFG_W  = 3;
   localparam int MODE_W = 4;
   localparam int CTL_W  = 16;
   localparam int STAT_W = 9;

   typedef logic [ADDR_W-1:0] gpt_addr_t;

   localparam gpt_addr_t OFS_CFG      = 8'h00;
   localparam gpt_addr_t OFS_MODE_A   = 8'h04;
   localparam gpt_addr_t OFS_MODE_B   = 8'h08;
   localparam gpt_addr_t OFS_CTL      = 8'h0C;
   localparam gpt_addr_t OFS_IMASK    = 8'h18;
   localparam gpt_addr_t OFS_RAW      = 8'h1C;
   localparam gpt_addr_t OFS_MSTAT    = 8'h20;
   localparam gpt_addr_t OFS_ICLR     = 8'h24;
   localparam gpt_addr_t OFS_LOAD_A   = 8'h28;
   localparam gpt_addr_t OFS_LOAD_B   = 8'h2C;
   localparam gpt_addr_t OFS_MATCH_A  = 8'h30;
   localparam gpt_addr_t OFS_MATCH_B  = 8'h34;
   localparam gpt_addr_t OFS_PRE_A    = 8'h38;
   localparam gpt_addr_t OFS_PRE_B    = 8'h3C;
   localparam gpt_addr_t OFS_PMATCH_A = 8'h40;
   localparam gpt_addr_t OFS_PMATCH_B = 8'h44;
   localparam gpt_addr_t OFS_RTC_VAL  = 8'h48;

   localparam int CTL_EN_A = 0;
   localparam int CTL_TRIG = 5;
   localparam int CTL_EN_B = 8;

   localparam int BIT_TO_A = 0;
   localparam int BIT_RTC  = 3;
   localparam int BIT_TO_B = 8;
   localparam logic [STAT_W-1:0] IMASK_KEEP = 9'h077;

   typedef enum logic [1:0] {
      OP_WIDE  = 2'd0,
      OP_RTC   = 2'd1,
      OP_SPLIT = 2'd2,
      OP_IDLE  = 2'd3
   } gpt_op_e;

   function automatic gpt_op_e decode_cfg(input logic [CFG_W-1:0] c);
      if (c == 3'd0)       return OP_WIDE;
      else if (c == 3'd1)  return OP_RTC;
      else if (c >= 3'd4)  return OP_SPLIT;
      else                 return OP_IDLE;
   endfunction
endpackage

// File: rtl/gpt_lane.sv
module gpt_lane #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             en,
   input  logic             start,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] load,
   input  logic [PRE_W-1:0] presc,
   output logic             timeout,
   output logic             stop_req
);
   logic [CNT_W-1:0] cnt;
   logic [PRE_W-1:0] pre;
   logic             running;
   logic             step;

   assign running  = active && en && !start;
   assign step     = running && (pre == presc);
   assign timeout  = step && (cnt == '0);
   assign stop_req = timeout && oneshot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         pre <= '0;
      end else if (start) begin
         cnt <= load;
         pre <= '0;
      end else if (running) begin
         if (step) begin
            pre <= '0;
            cnt <= (cnt == '0) ? load : cnt - 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gpt_rtc.sv
module gpt_rtc #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             en,
   input  logic             start,
   input  logic             tick,
   input  logic [CNT_W-1:0] load,
   input  logic [CNT_W-1:0] match,
   output logic [CNT_W-1:0] value,
   output logic             hit
);
   logic [CNT_W-1:0] nxt;
   logic             advance;

   assign nxt     = value + 1'b1;
   assign advance = active && en && !start && tick;
   assign hit     = advance && (nxt == match);

   always_ff @(posedge clk) begin
      if (!rst_n)       value <= '0;
      else if (start)   value <= load;
      else if (advance) value <= nxt;
   end
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int PRE_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [STAT_W-1:0]    stat_set,
   input  logic [1:0]           stop_req,
   input  logic [2*HALF_W-1:0]  rtc_val,
   output gpt_op_e              op,
   output logic [1:0]           en,
   output logic                 trig_en,
   output logic [1:0]           oneshot,
   output logic [1:0]           start,
   output logic [HALF_W-1:0]    load_a,
   output logic [HALF_W-1:0]    load_b,
   output logic [HALF_W-1:0]    match_a,
   output logic [HALF_W-1:0]    match_b,
   output logic [PRE_W-1:0]     pre_a,
   output logic [PRE_W-1:0]     pre_b,
   output logic [STAT_W-1:0]    raw,
   output logic [STAT_W-1:0]    imask
);
   localparam int FULL_W = 2 * HALF_W;

   logic [CFG_W-1:0]  cfg;
   logic [MODE_W-1:0] mode_a, mode_b;
   logic [CTL_W-1:0]  ctl;
   logic [PRE_W-1:0]  pm_a, pm_b;
   logic [STAT_W-1:0] clr;
   logic              wide;
   logic [HALF_W-1:0] w_lo, w_hi;

   assign op      = decode_cfg(cfg);
   assign wide    = (op != OP_SPLIT);
   assign w_lo    = bus_wdata[HALF_W-1:0];
   assign w_hi    = bus_wdata[FULL_W-1:HALF_W];
   assign en      = {ctl[CTL_EN_B], ctl[CTL_EN_A]};
   assign trig_en = ctl[CTL_TRIG];
   assign oneshot = {mode_b[0], mode_a[0]};
   assign clr     = (bus_wr && bus_addr == OFS_ICLR) ? bus_wdata[STAT_W-1:0] : '0;

   always_comb begin
      start = '0;
      if (bus_wr && bus_addr == OFS_CTL) begin
         start[0] = bus_wdata[CTL_EN_A] && !ctl[CTL_EN_A];
         start[1] = bus_wdata[CTL_EN_B] && !ctl[CTL_EN_B];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0; mode_a <= '0; mode_b <= '0; ctl <= '0;
         load_a <= '0; load_b <= '0; match_a <= '0; match_b <= '0;
         pre_a <= '0; pre_b <= '0; pm_a <= '0; pm_b <= '0;
         imask <= '0;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               OFS_CFG:      cfg    <= bus_wdata[CFG_W-1:0];
               OFS_MODE_A:   mode_a <= bus_wdata[MODE_W-1:0];
               OFS_MODE_B:   mode_b <= bus_wdata[MODE_W-1:0];
               OFS_IMASK:    imask  <= bus_wdata[STAT_W-1:0] & IMASK_KEEP;
               OFS_LOAD_A: begin
                  load_a <= w_lo;
                  if (wide) load_b <= w_hi;
               end
               OFS_LOAD_B:   load_b <= w_lo;
               OFS_MATCH_A: begin
                  match_a <= w_lo;
                  if (wide) match_b <= w_hi;
               end
               OFS_MATCH_B:  match_b <= w_lo;
               OFS_PRE_A:    pre_a  <= bus_wdata[PRE_W-1:0];
               OFS_PRE_B:    pre_b  <= bus_wdata[PRE_W-1:0];
               OFS_PMATCH_A: pm_a   <= bus_wdata[PRE_W-1:0];
               OFS_PMATCH_B: pm_b   <= bus_wdata[PRE_W-1:0];
               default: ;
            endcase
         end
         if (bus_wr && bus_addr == OFS_CTL) begin
            ctl <= bus_wdata[CTL_W-1:0];
         end else begin
            if (stop_req[0]) ctl[CTL_EN_A] <= 1'b0;
            if (stop_req[1]) ctl[CTL_EN_B] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) raw <= '0;
      else        raw <= (raw & ~clr) | stat_set;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CFG:      bus_rdata[CFG_W-1:0]  = cfg;
         OFS_MODE_A:   bus_rdata[MODE_W-1:0] = mode_a;
         OFS_MODE_B:   bus_rdata[MODE_W-1:0] = mode_b;
         OFS_CTL:      bus_rdata[CTL_W-1:0]  = ctl;
         OFS_IMASK:    bus_rdata[STAT_W-1:0] = imask;
         OFS_RAW:      bus_rdata[STAT_W-1:0] = raw;
         OFS_MSTAT:    bus_rdata[STAT_W-1:0] = raw & imask;
         OFS_LOAD_A:   bus_rdata[FULL_W-1:0] = wide ? {load_b, load_a} : {{HALF_W{1'b0}}, load_a};
         OFS_LOAD_B:   bus_rdata[HALF_W-1:0] = load_b;
         OFS_MATCH_A:  bus_rdata[FULL_W-1:0] = wide ? {match_b, match_a} : {{HALF_W{1'b0}}, match_a};
         OFS_MATCH_B:  bus_rdata[HALF_W-1:0] = match_b;
         OFS_PRE_A:    bus_rdata[PRE_W-1:0]  = pre_a;
         OFS_PRE_B:    bus_rdata[PRE_W-1:0]  = pre_b;
         OFS_PMATCH_A: bus_rdata[PRE_W-1:0]  = pm_a;
         OFS_PMATCH_B: bus_rdata[PRE_W-1:0]  = pm_b;
         OFS_RTC_VAL:  if (op == OP_RTC) bus_rdata[FULL_W-1:0] = rtc_val;
         default: ;
      endcase
   end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gpt_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int PRE_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rtc_tick,
   output logic              irq,
   output logic              trig
);
   localparam int FULL_W  = 2 * HALF_W;
   localparam int N_LANES = 2;

   if (HALF_W < 4 || FULL_W > DATA_W || PRE_W < 1 || PRE_W > DATA_W
       || STAT_W > DATA_W || CTL_W > DATA_W) begin : g_bad_params
      $error("gp_timer: parameter set does not fit the register bus");
   end

   gpt_op_e             op;
   logic [1:0]          en, oneshot, start, stop_req;
   logic                trig_en;
   logic [HALF_W-1:0]   load_a, load_b, match_a, match_b;
   logic [PRE_W-1:0]    pre_a, pre_b;
   logic [STAT_W-1:0]   raw, imask, stat_set;
   logic [FULL_W-1:0]   rtc_val;
   logic                rtc_hit;
   logic [N_LANES-1:0]  lane_to, lane_active;
   logic [FULL_W-1:0]   lane_load [N_LANES];
   logic [PRE_W-1:0]    lane_pre  [N_LANES];

   gpt_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_set(stat_set),
      .stop_req(stop_req), .rtc_val(rtc_val), .op(op), .en(en),
      .trig_en(trig_en), .oneshot(oneshot), .start(start),
      .load_a(load_a), .load_b(load_b), .match_a(match_a), .match_b(match_b),
      .pre_a(pre_a), .pre_b(pre_b), .raw(raw), .imask(imask)
   );

   always_comb begin
      lane_active[0] = (op == OP_WIDE) || (op == OP_SPLIT);
      lane_active[1] = (op == OP_SPLIT);
      lane_load[0]   = (op == OP_WIDE) ? {load_b, load_a} : {{HALF_W{1'b0}}, load_a};
      lane_load[1]   = {{HALF_W{1'b0}}, load_b};
      lane_pre[0]    = pre_a;
      lane_pre[1]    = pre_b;
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      gpt_lane #(.CNT_W(FULL_W), .PRE_W(PRE_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .active(lane_active[i]), .en(en[i]),
         .start(start[i]), .oneshot(oneshot[i]), .load(lane_load[i]),
         .presc(lane_pre[i]), .timeout(lane_to[i]), .stop_req(stop_req[i])
      );
   end

   gpt_rtc #(.CNT_W(FULL_W)) u_rtc (
      .clk(clk), .rst_n(rst_n), .active(op == OP_RTC), .en(en[0]),
      .start(start[0]), .tick(rtc_tick), .load({load_b, load_a}),
      .match({match_b, match_a}), .value(rtc_val), .hit(rtc_hit)
   );

   always_comb begin
      stat_set           = '0;
      stat_set[BIT_TO_A] = lane_to[0];
      stat_set[BIT_RTC]  = rtc_hit;
      stat_set[BIT_TO_B] = lane_to[1];
   end

   assign irq = |(raw & imask);

   always_ff @(posedge clk) begin
      if (!rst_n) trig <= 1'b0;
      else        trig <= lane_to[0] && (op == OP_WIDE) && trig_en;
   end
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk
   import gpt_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [7:0]        bus_addr,
   input logic              trig,
   input logic              irq,
   input gpt_op_e           op,
   input logic              en_a,
   input logic              trig_en,
   input logic [STAT_W-1:0] raw,
   input logic              to_a,
   input logic              oneshot_a
);
   // R5
   trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> raw[BIT_TO_A]);

   // R5
   trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> ($past(op) == OP_WIDE && $past(trig_en)));

   // R4
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (to_a && oneshot_a && !(bus_wr && bus_addr == OFS_CTL)) |=> !en_a);

   // R7
   split_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[BIT_TO_B]) |-> ($past(op) == OP_SPLIT));

   // R6
   rtc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[BIT_RTC]) |-> ($past(op) == OP_RTC));

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((raw & IMASK_KEEP) != '0));
endmodule

bind gp_timer gpt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .trig(trig), .irq(irq), .op(op), .en_a(en[0]), .trig_en(trig_en),
   .raw(raw), .to_a(lane_to[0]), .oneshot_a(oneshot[0])
);

// File: tb/gp_timer_test.sv
module gp_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rtc_tick = 1'b0;
   logic        irq, trig;

   int cyc = 0;
   int nchk = 0;
   int nfail = 0;
   int last_edge = 0;
   int exp_q[$];

   gp_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
      .irq(irq), .trig(trig)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      last_edge = cyc;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic tick_once();
      rtc_tick = 1'b1;
      @(posedge clk); #1;
      rtc_tick = 1'b0;
   endtask

   // scoreboard monitor: every trigger pulse must match a predicted cycle (R5, R2, R3)
   always @(negedge clk) begin
      if (rst_n && trig) begin
         if (exp_q.size() == 0) begin
            check("R5 unexpected trig pulse", cyc, 32'hFFFF_FFFF);
         end else begin
            int e;
            e = exp_q.pop_front();
            check("R2 R3 trig pulse cycle", cyc, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int e;
      for (int i = 0; i < 4; i++) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); check("R1 cfg", v, 0);
      rd(8'h0C, v); check("R1 ctl", v, 0);
      rd(8'h1C, v); check("R1 raw", v, 0);
      rd(8'h18, v); check("R1 mask", v, 0);
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 trig", {31'd0, trig}, 0);

      // R2 R3 periodic joined counter, trigger on; bit 8 must do nothing (R7)
      wr(8'h00, 0); wr(8'h04, 0); wr(8'h38, 2); wr(8'h28, 5);
      rd(8'h28, v); check("R8 wide load readback", v, 5);
      wr(8'h0C, 32'h121);
      e = last_edge;
      exp_q.push_back(e + 18); exp_q.push_back(e + 36); exp_q.push_back(e + 54);
      wait_to(e + 60);
      wr(8'h0C, 0);
      rd(8'h1C, v); check("R3 raw A after periods", v[0], 1);
      check("R7 bit8 inert in cfg0", v[8], 0);
      check("R3 all pulses seen", exp_q.size(), 0);

      // R2 R4 R8 one-shot with load in upper half
      wr(8'h24, 32'h1FF);
      wr(8'h04, 1); wr(8'h38, 0); wr(8'h28, 32'h0001_0000);
      rd(8'h28, v); check("R8 combined load readback", v, 32'h0001_0000);
      rd(8'h2C, v); check("R8 upper half into B", v, 1);
      wr(8'h0C, 32'h21);
      e = last_edge;
      exp_q.push_back(e + 65537);
      wait_to(e + 65536);
      rd(8'h1C, v); check("R2 no timeout before interval", v[0], 0);
      wait_to(e + 65537);
      rd(8'h1C, v); check("R2 timeout at interval", v[0], 1);
      wait_to(e + 65545);
      rd(8'h0C, v); check("R4 enable cleared by one-shot", v, 32'h20);
      check("R4 pulse consumed", exp_q.size(), 0);

      // R9 R10 mask, interrupt and clear; trigger off (R5)
      wr(8'h24, 32'h1FF);
      wr(8'h18, 32'h1FF);
      rd(8'h18, v); check("R9 mask keeps 0x77", v, 32'h77);
      check("R9 irq low with empty status", {31'd0, irq}, 0);
      wr(8'h28, 2);
      wr(8'h0C, 32'h01);
      e = last_edge;
      wait_to(e + 2);
      check("R9 irq before timeout", {31'd0, irq}, 0);
      wait_to(e + 3);
      check("R9 irq at timeout", {31'd0, irq}, 1);
      rd(8'h20, v); check("R9 masked status", v, 1);
      wr(8'h24, 1);
      check("R10 irq after clear", {31'd0, irq}, 0);
      rd(8'h1C, v); check("R10 raw after clear", v, 0);

      // R6 real-time counter
      wr(8'h0C, 0);
      wr(8'h00, 1); wr(8'h28, 10); wr(8'h30, 13);
      rd(8'h30, v); check("R8 combined match readback", v, 13);
      wr(8'h0C, 1);
      tick_once(); tick_once();
      rd(8'h48, v); check("R6 value after two ticks", v, 12);
      rd(8'h1C, v); check("R6 no match yet", v[3], 0);
      tick_once();
      rd(8'h1C, v); check("R6 match flag", v[3], 1);
      rd(8'h48, v); check("R6 value at match", v, 13);
      check("R9 match bit outside mask", {31'd0, irq}, 0);
      wr(8'h0C, 0);

      // R7 R8 split lanes, trigger bit set but must not pulse (R5)
      wr(8'h24, 32'h1FF);
      wr(8'h00, 4); wr(8'h04, 0); wr(8'h08, 0);
      wr(8'h2C, 6); wr(8'h28, 32'h0009_0003);
      rd(8'h2C, v); check("R8 split keeps B load", v, 6);
      rd(8'h28, v); check("R8 split reads A half", v, 3);
      wr(8'h38, 0); wr(8'h3C, 1);
      wr(8'h0C, 32'h121);
      e = last_edge;
      wait_to(e + 3);
      rd(8'h1C, v); check("R7 lane A before", v[0], 0);
      wait_to(e + 4);
      rd(8'h1C, v); check("R7 lane A timeout", v[0], 1);
      wait_to(e + 13);
      rd(8'h1C, v); check("R7 lane B before", v[8], 0);
      wait_to(e + 14);
      rd(8'h1C, v); check("R7 lane B timeout", v[8], 1);
      wr(8'h0C, 0);
      repeat (3) @(posedge clk);
      #1;
      check("R5 no pending pulses", exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule